// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Stream Handshake

This block multiplies two N-bit operands (N = 16 by default) and returns the exact 2N-bit product. A single mode pin chooses whether the operands are read as two's-complement or as plain unsigned numbers. The multiplier operand is recoded into radix-4 digits taken from overlapping bit triples. Each digit picks zero, one or two times the multiplicand, possibly negated, as a shifted and fully sign-extended row. A tree of 4:2 compressors folds the rows into a sum row and a carry row. A final adder then joins them. It is built from 4-bit ripple segments, and each segment after the first picks between two precomputed results.

Operands enter through a valid/ready stream and products leave through a second valid/ready stream. Internally there are two register stages. The operand stage loads only when a transfer takes place, so the whole arithmetic datapath stays still whenever no new input arrives. The result stage holds the product until the consumer takes it. A transfer happens on a rising edge where valid and ready are both high. A producer may hold valid high for as long as it likes. The consumer may drop out_ready at any time, and the stall then reaches back to in_ready, so no item is dropped or reordered.

Top module: `booth_mul`

## Requirements
- R1: While rst is high, and on the first edges after it falls, out_valid is 0 and in_ready is 1.
- R2: With in_signed = 0, out_prod equals the unsigned product of in_a and in_b, bit-exact over all 2N bits, including 0, 1 and all-ones operands.
- R3: With in_signed = 1, out_prod equals the two's-complement product as a 2N-bit two's-complement value, including the most negative value times itself.
- R4: An input accepted on edge k, with out_ready high, is presented with out_valid = 1 after edge k+1 and not before.
- R5: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_prod does not change.
- R6: in_ready is 0 only when both internal stages are full and out_ready is 0. An item that is held this way is neither lost nor reordered.
- R7: When no transfer takes place on in_a/in_b (in_valid = 0), the operand registers keep their values, and the values on in_a and in_b produce no output.
- R8: Multiplier digits are recoded from triples (bit 2i+1, bit 2i, bit 2i-1, with bit -1 = 0). 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. Alternating bit patterns of the multiplier give exact products.
- R9: The sum of the two reduced rows from the hybrid ripple/select adder equals their full 2N-bit binary sum, including carries that ripple across every segment.
- R10: The same RTL built with N = 8 gives exact products for every operand pair in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block accepts an operand pair on this edge |
| in_a | input | N | Multiplicand |
| in_b | input | N | Multiplier (the Booth-recoded operand) |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| out_valid | output | 1 | out_prod holds a result |
| out_ready | input | 1 | The consumer takes the result on this edge |
| out_prod | output | 2N | Product |

## Verification
On every cycle the assertions check several things: the held operands while no transfer occurs, a stalled result that stays frozen, and a held stage-one item while the output is blocked. They also check that an arriving result comes from a filled operand stage, that the final adder equals a plain binary sum, and that the pre-register product equals a behavioural multiply in both modes. Only the bench scenarios can show the rest. These are the exact cycle of the first result after an idle period, the point at which in_ready falls under a sustained stall, and the fact that inputs toggled under in_valid = 0 create no output. They also cover the full 8-bit sweep in both modes and the signed and unsigned corner operands.

// File: rtl/booth_pkg.sv
`timescale 1ns/1ps
package booth_pkg;

  // Selection produced by one radix-4 digit.
  typedef struct packed {
    logic one;   // select 1x multiplicand
    logic two;   // select 2x multiplicand
    logic neg;   // negate the selection
  } booth_dig_t;

  // R8: triple {b[2i+1], b[2i], b[2i-1]} -> digit
  function automatic booth_dig_t recode(input logic [2:0] t);
    booth_dig_t d;
    d.one = t[1] ^ t[0];
    d.two = (t == 3'b011) || (t == 3'b100);
    d.neg = t[2] & ~(t[1] & t[0]);
    return d;
  endfunction

  // Smallest power of two, at least 4, holding n rows.
  function automatic int tree_rows(input int n);
    int r;
    r = 4;
    while (r < n) r = r * 2;
    return r;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
`timescale 1ns/1ps
module booth_pp_gen #(
  parameter int N  = 16,
  parameter int PW = 2 * N,
  parameter int ND = N / 2 + 1
) (
  input  logic [N-1:0]  x,
  input  logic [N-1:0]  y,
  input  logic          sgn,
  output logic [PW-1:0] rows [ND+1]
);
  import booth_pkg::*;

  localparam int MW = N + 2;   // width of a selected multiple

  logic          xe_bit, ye_bit;
  logic [N:0]    x_ext;
  logic [N+2:0]  y_pad;        // {ext, ext, y, implicit 0}
  logic [ND-1:0] neg_v;
  logic [PW-1:0] corr;

  assign xe_bit = sgn & x[N-1];
  assign ye_bit = sgn & y[N-1];
  assign x_ext  = {xe_bit, x};
  assign y_pad  = {ye_bit, ye_bit, y, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    booth_dig_t    d;
    logic [MW-1:0] mag, val;
    logic [PW-1:0] wide;

    assign d    = recode(y_pad[2*i+2 : 2*i]);
    assign mag  = ({MW{d.one}} & {x_ext[N], x_ext}) |
                  ({MW{d.two}} & {x_ext, 1'b0});
    // single path: one's complement here, +1 through the correction row
    assign val  = mag ^ {MW{d.neg}};
    assign wide = {{(PW-MW){val[MW-1]}}, val};
    assign rows[i]  = wide << (2 * i);
    assign neg_v[i] = d.neg;
  end

  always_comb begin
    corr = '0;
    for (int i = 0; i < ND; i++) corr[2*i] = neg_v[i];
  end

  assign rows[ND] = corr;

endmodule

// File: rtl/booth_csa42.sv
`timescale 1ns/1ps
module booth_csa42 #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] s1, c1;

  // first full-adder layer, its carry moves one column up
  assign s1 = a ^ b ^ c;
  assign c1 = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) |
               (b[W-2:0] & c[W-2:0]), 1'b0};
  // second layer absorbs the fourth row and the inner carry
  assign s  = s1 ^ c1 ^ d;
  assign cy = {(s1[W-2:0] & c1[W-2:0]) | (s1[W-2:0] & d[W-2:0]) |
               (c1[W-2:0] & d[W-2:0]), 1'b0};

endmodule

// File: rtl/booth_csa_tree.sv
`timescale 1ns/1ps
module booth_csa_tree #(
  parameter int W   = 32,
  parameter int NIN = 10
) (
  input  logic [W-1:0] rows [NIN],
  output logic [W-1:0] sum_row,
  output logic [W-1:0] car_row
);
  import booth_pkg::*;

  localparam int NR     = tree_rows(NIN);
  localparam int LEVELS = $clog2(NR) - 1;
  localparam int NODES  = 2 * NR - 2;

  // all levels packed back to back: level l starts at 2*NR - 2*(NR>>l)
  logic [W-1:0] node [NODES];

  for (genvar j = 0; j < NR; j++) begin : g_in
    if (j < NIN) begin : g_row
      assign node[j] = rows[j];
    end else begin : g_pad
      assign node[j] = '0;
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int OFF_I = 2 * NR - 2 * (NR >> l);
    localparam int OFF_O = 2 * NR - 2 * (NR >> (l + 1));
    for (genvar k = 0; k < (NR >> l) / 4; k++) begin : g_cmp
      booth_csa42 #(.W(W)) u_c (
        .a (node[OFF_I + 4*k]),
        .b (node[OFF_I + 4*k + 1]),
        .c (node[OFF_I + 4*k + 2]),
        .d (node[OFF_I + 4*k + 3]),
        .s (node[OFF_O + 2*k]),
        .cy(node[OFF_O + 2*k + 1])
      );
    end
  end

  assign sum_row = node[NODES-2];
  assign car_row = node[NODES-1];

endmodule

// File: rtl/booth_csel_adder.sv
`timescale 1ns/1ps
module booth_csel_adder #(
  parameter int W   = 32,
  parameter int SEG = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int NS = W / SEG;

  logic [NS-1:0] cin;

  assign cin[0] = 1'b0;

  for (genvar k = 0; k < NS; k++) begin : g_seg
    localparam int LO = k * SEG;
    if (k == 0) begin : g_first
      logic [SEG:0] r;
      assign r = {1'b0, a[LO +: SEG]} + {1'b0, b[LO +: SEG]};
      assign sum[LO +: SEG] = r[SEG-1:0];
      if (NS > 1) begin : g_c
        assign cin[1] = r[SEG];
      end
    end else if (k == NS - 1) begin : g_last
      logic [SEG-1:0] r0, r1;
      assign r0 = a[LO +: SEG] + b[LO +: SEG];
      assign r1 = a[LO +: SEG] + b[LO +: SEG] + 1'b1;
      assign sum[LO +: SEG] = cin[k] ? r1 : r0;
    end else begin : g_mid
      logic [SEG:0] r0, r1;
      assign r0 = {1'b0, a[LO +: SEG]} + {1'b0, b[LO +: SEG]};
      assign r1 = {1'b0, a[LO +: SEG]} + {1'b0, b[LO +: SEG]} + 1'b1;
      assign sum[LO +: SEG] = cin[k] ? r1[SEG-1:0] : r0[SEG-1:0];
      assign cin[k+1]       = cin[k] ? r1[SEG] : r0[SEG];
    end
  end

endmodule

// File: rtl/booth_mul.sv
`timescale 1ns/1ps
module booth_mul #(
  parameter int N   = 16,
  parameter int SEG = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  input  logic           in_signed,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] out_prod
);
  localparam int PW = 2 * N;
  localparam int ND = N / 2 + 1;

  logic [N-1:0]  a_q, b_q;
  logic          sgn_q, s1_valid;
  logic          s1_ready, s2_ready;
  logic [PW-1:0] rows [ND+1];
  logic [PW-1:0] t_sum, t_car, prod_c;

  assign s2_ready = !out_valid || out_ready;
  assign s1_ready = !s1_valid || s2_ready;
  assign in_ready = s1_ready;            // R6

  // operand stage; loads only on a transfer (R7 isolation), R1 reset
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      sgn_q    <= 1'b0;
    end else begin
      if (s1_ready) s1_valid <= in_valid;
      if (in_valid && s1_ready) begin
        a_q   <= in_a;
        b_q   <= in_b;
        sgn_q <= in_signed;
      end
    end
  end

  booth_pp_gen #(.N(N), .PW(PW), .ND(ND)) u_pp (
    .x(a_q), .y(b_q), .sgn(sgn_q), .rows(rows)
  );

  booth_csa_tree #(.W(PW), .NIN(ND + 1)) u_tree (
    .rows(rows), .sum_row(t_sum), .car_row(t_car)
  );

  booth_csel_adder #(.W(PW), .SEG(SEG)) u_add (
    .a(t_sum), .b(t_car), .sum(prod_c)
  );

  // result stage (R4, R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      if (s2_ready) out_valid <= s1_valid;
      if (s1_valid && s2_ready) out_prod <= prod_c;
    end
  end

  // behavioural model used only by the checks below
  function automatic logic [PW-1:0] model_mul(input logic [N-1:0] a,
                                               input logic [N-1:0] b,
                                               input logic s);
    logic [PW-1:0] ea, eb;
    ea = {{N{s & a[N-1]}}, a};
    eb = {{N{s & b[N-1]}}, b};
    return ea * eb;
  endfunction

  assert_hold_operands_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(a_q) && $stable(b_q) && $stable(sgn_q));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  assert_stage_kept_R6: assert property (@(posedge clk) disable iff (rst)
    s1_valid && out_valid && !out_ready |=> s1_valid && $stable(a_q) && $stable(b_q));

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(s1_valid));

  assert_adder_R9: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> prod_c == t_sum + t_car);

  assert_unsigned_R2: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !sgn_q |-> prod_c == model_mul(a_q, b_q, 1'b0));

  assert_signed_R3: assert property (@(posedge clk) disable iff (rst)
    s1_valid && sgn_q |-> prod_c == model_mul(a_q, b_q, 1'b1));

endmodule

// File: tb/tb_booth_mul.sv
`timescale 1ns/1ps
module tb_booth_mul;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // 16-bit instance
  logic        in_valid = 1'b0, in_signed = 1'b0, out_ready = 1'b1;
  logic [15:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_prod;

  // 8-bit instance
  logic        v8 = 1'b0, s8 = 1'b0, ordy8 = 1'b1;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        irdy8, ov8;
  logic [15:0] p8;

  booth_mul #(.N(16)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  booth_mul #(.N(8)) dut8 (
    .clk(clk), .rst(rst), .in_valid(v8), .in_ready(irdy8),
    .in_a(a8), .in_b(b8), .in_signed(s8),
    .out_valid(ov8), .out_ready(ordy8), .out_prod(p8)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ready_mode = 0;    // 0 always ready, 1 random, 2 stalled
  bit done = 1'b0;

  logic [31:0] q16 [$];
  string       t16 [$];
  logic [15:0] q8  [$];

  function automatic logic [31:0] ref16(input logic [15:0] a, input logic [15:0] b,
                                        input logic s);
    logic [31:0] ea, eb;
    ea = {{16{s & a[15]}}, a};
    eb = {{16{s & b[15]}}, b};
    return ea * eb;
  endfunction

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b,
                                       input logic s);
    logic [15:0] ea, eb;
    ea = {{8{s & a[7]}}, a};
    eb = {{8{s & b[7]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: caller sits at a negedge
  task automatic push16(input logic [15:0] a, input logic [15:0] b,
                        input logic s, input string req);
    in_a = a; in_b = b; in_signed = s; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q16.push_back(ref16(a, b, s));
    t16.push_back(req);
    @(negedge clk);
  endtask

  task automatic idle16(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_a = 16'($urandom); in_b = 16'($urandom); in_signed = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic push8(input logic [7:0] a, input logic [7:0] b, input logic s);
    a8 = a; b8 = b; s8 = s; v8 = 1'b1;
    while (!irdy8) @(negedge clk);
    q8.push_back(ref8(a, b, s));
    @(negedge clk);
  endtask

  // consumer ready, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 4) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitors
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (q16.size() == 0) chk(1'b0, "R6 unexpected result", out_prod, 32'h0);
      else begin
        logic [31:0] e;
        string tg;
        e  = q16.pop_front();
        tg = t16.pop_front();
        chk(out_prod == e, tg, out_prod, e);
      end
    end
    if (!rst && ov8 && ordy8) begin
      if (q8.size() == 0) chk(1'b0, "R10 unexpected result", {16'h0, p8}, 32'h0);
      else begin
        logic [15:0] e8;
        e8 = q8.pop_front();
        chk(p8 == e8, "R10 8-bit sweep", {16'h0, p8}, {16'h0, e8});
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog (all) actual=%0d cycles expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [5];
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
    corner[3] = 16'h8000; corner[4] = 16'h7FFF;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
    chk(ov8 == 1'b0, "R1 out_valid in reset (8-bit)", {31'h0, ov8}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'h0, in_ready}, 32'h1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'h0, out_valid}, 32'h0);

    fork
      begin : sweep8
        for (int s = 0; s < 2; s++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
              push8(8'(a), 8'(b), 1'(s));
        v8 = 1'b0;
      end
      begin : main16
        // R7: toggling inputs while in_valid is low creates no output
        idle16(1);
        for (int i = 0; i < 6; i++) begin
          in_a = 16'($urandom); in_b = 16'($urandom);
          @(negedge clk);
          chk(out_valid == 1'b0, "R7 no output from idle inputs",
              {31'h0, out_valid}, 32'h0);
        end

        // R4: latency of a single item from idle
        push16(16'h1234, 16'h5678, 1'b0, "R4 latency value");
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R4 not valid after acceptance edge",
            {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R4 valid one edge later", {31'h0, out_valid}, 32'h1);
        idle16(3);

        // corner operands in both modes
        for (int s = 0; s < 2; s++)
          for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
              push16(corner[i], corner[j], 1'(s), s ? "R3 corner" : "R2 corner");

        // R9: carries spanning every adder segment
        push16(16'hFFFF, 16'hFFFF, 1'b0, "R9 long carry");
        push16(16'h8000, 16'h8000, 1'b1, "R9 min*min");
        push16(16'hFFFF, 16'h0001, 1'b1, "R9 minus one");

        // R8: multiplier patterns hitting each triple code
        begin
          logic [15:0] pat [5];
          pat[0] = 16'hAAAA; pat[1] = 16'h5555; pat[2] = 16'h3333;
          pat[3] = 16'hCCCC; pat[4] = 16'h6666;
          for (int s = 0; s < 2; s++)
            for (int i = 0; i < 5; i++) begin
              push16(16'h1234, pat[i], 1'(s), "R8 recoding");
              push16(16'h8001, pat[i], 1'(s), "R8 recoding");
            end
        end
        idle16(4);

        // R5 and R6: stall the consumer
        ready_mode = 2;
        idle16(3);
        push16(16'h00F1, 16'h0203, 1'b0, "R5 stalled first");
        push16(16'hF00D, 16'h0ACE, 1'b1, "R6 stalled second");
        in_a = 16'h7777; in_b = 16'h9999; in_signed = 1'b1; in_valid = 1'b1;
        chk(in_ready == 1'b0, "R6 in_ready low when full", {31'h0, in_ready}, 32'h0);
        chk(out_prod == ref16(16'h00F1, 16'h0203, 1'b0), "R5 stalled value",
            out_prod, ref16(16'h00F1, 16'h0203, 1'b0));
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(out_valid == 1'b1, "R5 valid held", {31'h0, out_valid}, 32'h1);
          chk(out_prod == ref16(16'h00F1, 16'h0203, 1'b0), "R5 value held",
              out_prod, ref16(16'h00F1, 16'h0203, 1'b0));
          chk(in_ready == 1'b0, "R6 still blocked", {31'h0, in_ready}, 32'h0);
        end
        ready_mode = 0;
        push16(16'h7777, 16'h9999, 1'b1, "R6 third after release");
        idle16(4);

        // random traffic with random back-pressure and gaps
        ready_mode = 1;
        for (int n = 0; n < 10000; n++) begin
          logic s;
          if (($urandom % 8) == 0) idle16(1);
          s = 1'($urandom);
          push16(16'($urandom), 16'($urandom), s, s ? "R3 random" : "R2 random");
        end
        in_valid = 1'b0;
        ready_mode = 0;
      end
    join

    while (q16.size() != 0 || q8.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 no extra results", {31'h0, out_valid}, 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule